// File: doc/BRIEF.md
# Dual-Channel Tunable Down-Converter

This block brings two streams of signed converter samples, A and B, down to complex baseband. A new sample arrives on each lane in every clock cycle. One phase accumulator with a 24-bit tuning word drives a shared sine/cosine table, so both lanes are mixed against exactly the same oscillator phase. Each lane produces an in-phase result and a quadrature result, each 24 bits wide. These are packed into one 48-bit output word, and a single valid strobe covers both lanes.

A pulse on the sync input restarts the oscillator from a programmable starting phase. The same pulse realigns the optional averaging decimator, which divides the output rate by 2, 4, 8 or 16. When down-conversion is switched off, the raw samples pass straight through with the same delay. This lets the downstream logic keep a single timing model whatever the mode.

Top module: `dual_ddc`

## Requirements
- R1: While reset is held, `out_valid` is 0 and both output words are all zeros.
- R2: With mixing on, I = round(x·cos φ) and Q = round(−x·sin φ), where the oscillator amplitude is unity. At the quarter-turn phases the results are exact: φ=0 gives (x, 0), φ=π/2 gives (0, −x), φ=π gives (−x, 0) and φ=3π/2 gives (0, x).
- R3: The phase advances by the tuning word once per sample, and 2^24 counts make one full turn. Bits [3:0] of the tuning word and bits [3:0] of the starting-phase word have no effect.
- R4: A sync high at a rising edge loads the phase with the starting-phase word. The sample presented in the cycle after that edge is mixed at this phase. A starting phase of 0x400000 means π/2 and 0x800000 means π.
- R5: Each output word holds I in bits [47:24] and Q in bits [23:0], both in two's complement.
- R6: Lane A and lane B use the same oscillator phase in the same cycle and have identical timing.
- R7: With decimation on, `dec_sel` codes 0, 1, 2 and 3 select N = 2, 4, 8 and 16. Each output is floor(sum of N mixed values / N), taken separately for I and Q. `out_valid` pulses for one cycle per N samples.
- R8: Sync restarts the decimator. If the sample in the cycle after the sync edge is numbered 0, the first average covers samples 0..N−1 and is valid in cycle N+3. The next average is valid in cycle 2N+3, and `out_valid` stays low in cycles 3..N+2.
- R9: With `ddc_en` low, I is the sample sign-extended to 24 bits, Q is zero, and `out_valid` is high every cycle.
- R10: Without decimation, whether mixing or passing through, the sample presented in cycle t appears on the output in cycle t+4.
- R11: With mixing on and decimation off, `out_valid` is high every cycle once the pipeline has filled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ddc_en | input | 1 | 1 = mix with oscillator, 0 = pass samples through |
| dec_en | input | 1 | 1 = average-and-decimate the mixed output |
| dec_sel | input | 2 | Decimation code: 0→2, 1→4, 2→8, 3→16 |
| tune_word | input | 24 | Phase increment per sample (bits [3:0] ignored) |
| phase_init | input | 24 | Phase loaded on sync (bits [3:0] ignored) |
| sync | input | 1 | Restart oscillator phase and decimator block |
| samp_a | input | 16 | Lane A signed sample |
| samp_b | input | 16 | Lane B signed sample |
| out_a | output | 48 | Lane A {I, Q} |
| out_b | output | 48 | Lane B {I, Q} |
| out_valid | output | 1 | Output words valid this cycle |

## Verification
A quarter-turn tuning word with constant, unequal lane inputs steps the oscillator through four exact phases, which separates sine from cosine, catches a wrong sign on Q and shows whether the two lanes share one phase. Changing inputs under a zero tuning word, and again in pass-through mode, pin down the four-cycle delay and the sign extension. Starting-phase words with junk in the low nibble, and a tuning word made only of low-nibble bits run for thousands of cycles, show whether the masking works. Varied sequences pushed through each of the four decimation codes after a sync test the block alignment, the floor rounding of negative sums and the spacing of the valid pulses.

// File: rtl/ddc_pkg.sv
`timescale 1ns/1ps
package ddc_pkg;

   // largest decimation shift selectable by the 2-bit code (factor 16)
   localparam int DEC_LOG2_MAX = 4;

   // rounded sample of amp*sin(2*pi*idx/n_pts), evaluated at elaboration
   function automatic int sine_point(input int idx, input int n_pts, input int amp);
      real ang;
      real val;
      ang = 2.0 * 3.14159265358979323846 * real'(idx) / real'(n_pts);
      val = real'(amp) * $sin(ang);
      if (val >= 0.0) return $rtoi(val + 0.5);
      else            return -$rtoi(-val + 0.5);
   endfunction

endpackage

// File: rtl/ddc_nco.sv
`timescale 1ns/1ps
module ddc_nco #(
   parameter int PHASE_W = 24,
   parameter int MASK_W  = 4,
   parameter int LUT_AW  = 8,
   parameter int SIN_W   = 18
)(
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     sync,
   input  logic [PHASE_W-1:0]       tune_word,
   input  logic [PHASE_W-1:0]       phase_init,
   output logic signed [SIN_W-1:0]  cos_o,
   output logic signed [SIN_W-1:0]  sin_o
);
   localparam int N_PTS = 1 << LUT_AW;
   localparam int QTR   = N_PTS / 4;
   localparam int AMP   = (1 << (SIN_W - 1)) - 1;
   localparam logic [PHASE_W-1:0] KEEP = {{(PHASE_W-MASK_W){1'b1}}, {MASK_W{1'b0}}};

   logic [PHASE_W-1:0]      tune_m;
   logic [PHASE_W-1:0]      init_m;
   logic [PHASE_W-1:0]      acc_q;
   logic [LUT_AW-1:0]       idx_s;
   logic [LUT_AW-1:0]       idx_c;
   logic signed [SIN_W-1:0] lut [N_PTS];

   assign tune_m = tune_word & KEEP;
   assign init_m = phase_init & KEEP;

   // full-cycle sine table computed at elaboration
   for (genvar k = 0; k < N_PTS; k++) begin : g_lut
      assign lut[k] = SIN_W'(ddc_pkg::sine_point(k, N_PTS, AMP));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    acc_q <= '0;
      else if (sync) acc_q <= init_m;
      else           acc_q <= acc_q + tune_m;
   end

   assign idx_s = acc_q[PHASE_W-1 -: LUT_AW];
   assign idx_c = idx_s + LUT_AW'(QTR);   // cosine leads sine by a quarter turn

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sin_o <= '0;
         cos_o <= '0;
      end else begin
         sin_o <= lut[idx_s];
         cos_o <= lut[idx_c];
      end
   end

   // R3: masked increments never touch the low phase bits between syncs
   a_r3_low_bits_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !sync |=> acc_q[MASK_W-1:0] == $past(acc_q[MASK_W-1:0]));

   // R4: a sync reloads the accumulator with the masked starting phase
   a_r4_sync_loads_init: assert property (@(posedge clk) disable iff (!rst_n)
      sync |=> acc_q == $past(init_m));

   // R2: zero phase yields a null sine and a full-scale cosine
   a_r2_zero_phase: assert property (@(posedge clk) disable iff (!rst_n)
      (idx_s == '0) |=> (sin_o == '0) && (cos_o == SIN_W'(AMP)));

endmodule

// File: rtl/ddc_mixer.sv
`timescale 1ns/1ps
module ddc_mixer #(
   parameter int IN_W  = 16,
   parameter int SIN_W = 18,
   parameter int OUT_W = 24
)(
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic signed [IN_W-1:0]   samp_i,
   input  logic signed [SIN_W-1:0]  cos_i,
   input  logic signed [SIN_W-1:0]  sin_i,
   output logic signed [OUT_W-1:0]  i_o,
   output logic signed [OUT_W-1:0]  q_o,
   output logic signed [IN_W-1:0]   raw_o
);
   localparam int PW = IN_W + SIN_W;   // full product width
   localparam int SH = SIN_W - 1;      // unity-gain scaling shift
   localparam int RW = PW - SH;        // width after scaling
   localparam logic signed [PW-1:0] HALF = PW'(64'sd1 <<< (SH - 1));

   logic signed [IN_W-1:0]  x_q;
   logic signed [IN_W-1:0]  raw2_q;
   logic signed [PW-1:0]    sx, cx, snx;
   logic signed [PW-1:0]    pi_q, pq_q;
   logic signed [RW-1:0]    ri, rq;
   logic signed [OUT_W-1:0] fi, fq;

   assign sx  = PW'(x_q);
   assign cx  = PW'(cos_i);
   assign snx = PW'(sin_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         x_q    <= '0;
         pi_q   <= '0;
         pq_q   <= '0;
         raw2_q <= '0;
      end else begin
         x_q    <= samp_i;          // aligns sample with registered table output
         pi_q   <= sx * cx;
         pq_q   <= -(sx * snx);
         raw2_q <= x_q;
      end
   end

   // round half up, then drop the scaling bits
   assign ri = RW'((pi_q + HALF) >>> SH);
   assign rq = RW'((pq_q + HALF) >>> SH);

   if (OUT_W >= RW) begin : g_extend
      assign fi = OUT_W'(ri);
      assign fq = OUT_W'(rq);
   end else begin : g_saturate
      localparam logic signed [RW-1:0] HI = RW'((64'sd1 <<< (OUT_W - 1)) - 64'sd1);
      localparam logic signed [RW-1:0] LO = -HI - RW'(1);
      always_comb begin
         if (ri > HI)      fi = OUT_W'(HI);
         else if (ri < LO) fi = OUT_W'(LO);
         else              fi = OUT_W'(ri);
         if (rq > HI)      fq = OUT_W'(HI);
         else if (rq < LO) fq = OUT_W'(LO);
         else              fq = OUT_W'(rq);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         i_o   <= '0;
         q_o   <= '0;
         raw_o <= '0;
      end else begin
         i_o   <= fi;
         q_o   <= fq;
         raw_o <= raw2_q;
      end
   end

   // R2: a null cosine weight gives a null I two edges later
   a_r2_null_weight_i: assert property (@(posedge clk) disable iff (!rst_n)
      (cos_i == '0) |=> ##1 (i_o == '0));

   // R2: a null sine weight gives a null Q two edges later
   a_r2_null_weight_q: assert property (@(posedge clk) disable iff (!rst_n)
      (sin_i == '0) |=> ##1 (q_o == '0));

endmodule

// File: rtl/ddc_decim.sv
`timescale 1ns/1ps
module ddc_decim #(
   parameter int IN_W  = 16,
   parameter int OUT_W = 24
)(
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     ddc_en,
   input  logic                     dec_en,
   input  logic [1:0]               dec_sel,
   input  logic                     mix_v,
   input  logic                     restart,
   input  logic signed [OUT_W-1:0]  mix_i,
   input  logic signed [OUT_W-1:0]  mix_q,
   input  logic signed [IN_W-1:0]   raw_i,
   output logic [2*OUT_W-1:0]       out_w,
   output logic                     out_v
);
   localparam int CW  = ddc_pkg::DEC_LOG2_MAX;
   localparam int AW  = OUT_W + CW;
   localparam int SHW = $clog2(CW + 1);

   logic [CW-1:0]        cnt_q;
   logic [CW-1:0]        lim;
   logic [SHW-1:0]       shamt;
   logic signed [AW-1:0] acc_i_q, acc_q_q;
   logic signed [AW-1:0] nxt_i, nxt_q;
   logic                 dec_act;

   assign dec_act = ddc_en & dec_en;
   assign shamt   = SHW'(dec_sel) + SHW'(1);
   assign lim     = CW'((32'd2 << dec_sel) - 32'd1);
   assign nxt_i   = acc_i_q + AW'(mix_i);
   assign nxt_q   = acc_q_q + AW'(mix_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         acc_i_q <= '0;
         acc_q_q <= '0;
         out_w   <= '0;
         out_v   <= 1'b0;
      end else if (!ddc_en) begin
         // pass-through: sign-extended sample in I, zero in Q
         out_v   <= mix_v;
         out_w   <= {OUT_W'(raw_i), {OUT_W{1'b0}}};
         cnt_q   <= '0;
         acc_i_q <= '0;
         acc_q_q <= '0;
      end else if (!dec_en) begin
         out_v   <= mix_v;
         out_w   <= {mix_i, mix_q};
         cnt_q   <= '0;
         acc_i_q <= '0;
         acc_q_q <= '0;
      end else if (restart) begin
         out_v   <= 1'b0;
         cnt_q   <= '0;
         acc_i_q <= '0;
         acc_q_q <= '0;
      end else if (mix_v && cnt_q == lim) begin
         out_v   <= 1'b1;
         out_w   <= {OUT_W'(nxt_i >>> shamt), OUT_W'(nxt_q >>> shamt)};
         cnt_q   <= '0;
         acc_i_q <= '0;
         acc_q_q <= '0;
      end else if (mix_v) begin
         out_v   <= 1'b0;
         cnt_q   <= cnt_q + CW'(1);
         acc_i_q <= nxt_i;
         acc_q_q <= nxt_q;
      end else begin
         out_v   <= 1'b0;
      end
   end

   // R8: a restart in decimating mode suppresses the next strobe
   a_r8_restart_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (restart && dec_act) |=> !out_v);

   // R7: the block counter never runs past the selected factor
   a_r7_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      dec_act |-> cnt_q <= lim);

endmodule

// File: rtl/dual_ddc.sv
`timescale 1ns/1ps
module dual_ddc #(
   parameter int IN_W    = 16,
   parameter int PHASE_W = 24,
   parameter int MASK_W  = 4,
   parameter int LUT_AW  = 8,
   parameter int SIN_W   = 18,
   parameter int OUT_W   = 24
)(
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    ddc_en,
   input  logic                    dec_en,
   input  logic [1:0]              dec_sel,
   input  logic [PHASE_W-1:0]      tune_word,
   input  logic [PHASE_W-1:0]      phase_init,
   input  logic                    sync,
   input  logic signed [IN_W-1:0]  samp_a,
   input  logic signed [IN_W-1:0]  samp_b,
   output logic [2*OUT_W-1:0]      out_a,
   output logic [2*OUT_W-1:0]      out_b,
   output logic                    out_valid
);
   localparam int NCH  = 2;
   localparam int PIPE = 3;   // table/sample, product, rounded stages

   if (MASK_W < 1 || MASK_W > PHASE_W - LUT_AW) begin : g_chk_mask
      $error("dual_ddc: MASK_W must be 1..PHASE_W-LUT_AW");
   end
   if (LUT_AW < 3) begin : g_chk_lut
      $error("dual_ddc: LUT_AW must be at least 3");
   end
   if (SIN_W < 3 || OUT_W <= IN_W) begin : g_chk_width
      $error("dual_ddc: SIN_W >= 3 and OUT_W > IN_W required");
   end

   logic signed [SIN_W-1:0] cos_w, sin_w;
   logic [PIPE-1:0]         vld_q;
   logic [PIPE-1:0]         sync_q;
   logic signed [IN_W-1:0]  chan_in  [NCH];
   logic [2*OUT_W-1:0]      chan_out [NCH];
   logic [NCH-1:0]          chan_v;

   assign chan_in[0] = samp_a;
   assign chan_in[1] = samp_b;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q  <= '0;
         sync_q <= '0;
      end else begin
         vld_q  <= {vld_q[PIPE-2:0], 1'b1};
         sync_q <= {sync_q[PIPE-2:0], sync};
      end
   end

   ddc_nco #(
      .PHASE_W (PHASE_W),
      .MASK_W  (MASK_W),
      .LUT_AW  (LUT_AW),
      .SIN_W   (SIN_W)
   ) u_nco (
      .clk        (clk),
      .rst_n      (rst_n),
      .sync       (sync),
      .tune_word  (tune_word),
      .phase_init (phase_init),
      .cos_o      (cos_w),
      .sin_o      (sin_w)
   );

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      logic signed [OUT_W-1:0] m_i, m_q;
      logic signed [IN_W-1:0]  m_raw;

      ddc_mixer #(
         .IN_W  (IN_W),
         .SIN_W (SIN_W),
         .OUT_W (OUT_W)
      ) u_mix (
         .clk    (clk),
         .rst_n  (rst_n),
         .samp_i (chan_in[c]),
         .cos_i  (cos_w),
         .sin_i  (sin_w),
         .i_o    (m_i),
         .q_o    (m_q),
         .raw_o  (m_raw)
      );

      ddc_decim #(
         .IN_W  (IN_W),
         .OUT_W (OUT_W)
      ) u_dec (
         .clk     (clk),
         .rst_n   (rst_n),
         .ddc_en  (ddc_en),
         .dec_en  (dec_en),
         .dec_sel (dec_sel),
         .mix_v   (vld_q[PIPE-1]),
         .restart (sync_q[PIPE-1]),
         .mix_i   (m_i),
         .mix_q   (m_q),
         .raw_i   (m_raw),
         .out_w   (chan_out[c]),
         .out_v   (chan_v[c])
      );
   end

   assign out_a     = chan_out[0];
   assign out_b     = chan_out[1];
   assign out_valid = &chan_v;

   // R6: both lanes strobe in the same cycles
   a_r6_lanes_in_step: assert property (@(posedge clk) disable iff (!rst_n)
      chan_v[0] == chan_v[1]);

   // R7: decimated strobes are never back to back
   a_r7_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && ddc_en && dec_en) |=> !(out_valid && ddc_en && dec_en));

   // R9: pass-through leaves the Q field empty on both lanes
   a_r9_bypass_q_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !ddc_en |=> (out_a[OUT_W-1:0] == '0) && (out_b[OUT_W-1:0] == '0));

   // R11 (and R9): every sample is strobed when not decimating
   a_r11_full_rate: assert property (@(posedge clk) disable iff (!rst_n)
      (!(ddc_en && dec_en) && vld_q[PIPE-1]) |=> out_valid);

endmodule

// File: tb/dual_ddc_bench.sv
`timescale 1ns/1ps
module dual_ddc_bench;

   logic               clk = 1'b0;
   logic               rst_n;
   logic               ddc_en, dec_en, sync;
   logic [1:0]         dec_sel;
   logic [23:0]        tune_word, phase_init;
   logic signed [15:0] samp_a, samp_b;
   logic [47:0]        out_a, out_b;
   logic               out_valid;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;   // 200 MHz

   dual_ddc u_dual_ddc (
      .clk        (clk),
      .rst_n      (rst_n),
      .ddc_en     (ddc_en),
      .dec_en     (dec_en),
      .dec_sel    (dec_sel),
      .tune_word  (tune_word),
      .phase_init (phase_init),
      .sync       (sync),
      .samp_a     (samp_a),
      .samp_b     (samp_b),
      .out_a      (out_a),
      .out_b      (out_b),
      .out_valid  (out_valid)
   );

   task automatic check(input string req, input logic [47:0] act, input logic [47:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [47:0] pack(input int i_val, input int q_val);
      return {24'(i_val), 24'(q_val)};
   endfunction

   function automatic int pat(input int k, input int seed);
      return ((k * 7919 + seed * 4057) % 60001) - 30000;
   endfunction

   task automatic t_reset();
      repeat (3) @(negedge clk);
      check("R1 valid in reset", 48'(out_valid), 48'd0);
      check("R1 out_a in reset", out_a, 48'd0);
      check("R1 out_b in reset", out_b, 48'd0);
      rst_n = 1'b1;
   endtask

   // R9 / R10: pass-through with sign extension and a 4-cycle delay
   task automatic t_bypass();
      ddc_en = 1'b0; dec_en = 1'b0;
      for (int c = 0; c < 12; c++) begin
         @(negedge clk);
         if (c >= 4) begin
            check("R9 R10 bypass lane A", out_a, pack(pat(c-4, 1), 0));
            check("R9 bypass lane B", out_b, pack(pat(c-4, 2), 0));
            check("R9 bypass valid", 48'(out_valid), 48'd1);
         end
         samp_a = 16'(pat(c, 1));
         samp_b = 16'(pat(c, 2));
      end
   endtask

   // R2 R4 R5 R6 R11: quarter-turn stepping with unequal lane inputs
   task automatic t_quarter(input logic [23:0] tw);
      int xa, xb, p;
      ddc_en = 1'b1; dec_en = 1'b0;
      tune_word = tw; phase_init = 24'h0;
      xa = 12345; xb = -20000;
      samp_a = 16'(xa); samp_b = 16'(xb);
      @(negedge clk); sync = 1'b1;
      for (int c = 0; c < 12; c++) begin
         @(negedge clk);
         if (c == 0) sync = 1'b0;
         if (c >= 4) begin
            p = (c - 4) % 4;
            case (p)
               0: begin check("R2 R5 phase 0 A", out_a, pack(xa, 0));   check("R6 phase 0 B", out_b, pack(xb, 0));   end
               1: begin check("R2 R5 phase pi/2 A", out_a, pack(0, -xa)); check("R6 phase pi/2 B", out_b, pack(0, -xb)); end
               2: begin check("R2 phase pi A", out_a, pack(-xa, 0));  check("R6 phase pi B", out_b, pack(-xb, 0));  end
               default: begin check("R2 phase 3pi/2 A", out_a, pack(0, xa)); check("R6 phase 3pi/2 B", out_b, pack(0, xb)); end
            endcase
            check("R11 mix valid", 48'(out_valid), 48'd1);
         end
      end
   endtask

   // R4 R3: starting phase with junk in the low nibble, zero tuning
   task automatic t_init(input logic [23:0] ph, input int qturns);
      int x;
      ddc_en = 1'b1; dec_en = 1'b0;
      tune_word = 24'h0; phase_init = ph;
      x = -9876; samp_a = 16'(x); samp_b = 16'(x);
      @(negedge clk); sync = 1'b1;
      for (int c = 0; c < 7; c++) begin
         @(negedge clk);
         if (c == 0) sync = 1'b0;
         if (c >= 4) begin
            if (qturns == 2) check("R4 R3 init pi", out_a, pack(-x, 0));
            else             check("R4 R3 init pi/2", out_a, pack(0, -x));
         end
      end
   endtask

   // R3: tuning word of low-nibble bits only must leave phase frozen
   task automatic t_tune_mask();
      ddc_en = 1'b1; dec_en = 1'b0;
      tune_word = 24'h00000F; phase_init = 24'h0;
      samp_a = 16'sd30000; samp_b = -16'sd30000;
      @(negedge clk); sync = 1'b1;
      @(negedge clk); sync = 1'b0;
      repeat (6000) @(negedge clk);
      check("R3 masked tune lane A", out_a, pack(30000, 0));
      check("R3 masked tune lane B", out_b, pack(-30000, 0));
   endtask

   // R10: mixing at zero phase keeps the same 4-cycle delay
   task automatic t_mix_latency();
      ddc_en = 1'b1; dec_en = 1'b0;
      tune_word = 24'h0; phase_init = 24'h0;
      @(negedge clk); sync = 1'b1;
      for (int c = 0; c < 12; c++) begin
         @(negedge clk);
         if (c == 0) sync = 1'b0;
         if (c >= 4) check("R10 mix latency", out_a, pack(pat(c-4, 5), 0));
         samp_a = 16'(pat(c, 5));
         samp_b = 16'(pat(c, 6));
      end
   endtask

   // R7 R8: block averaging aligned to sync for one code
   task automatic t_decim(input int code);
      int n, sh, sa, sb;
      n = 2 << code; sh = code + 1;
      ddc_en = 1'b1; dec_en = 1'b1; dec_sel = 2'(code);
      tune_word = 24'h0; phase_init = 24'h0;
      @(negedge clk); sync = 1'b1;
      for (int c = 0; c <= 2*n + 3; c++) begin
         @(negedge clk);
         if (c == 0) sync = 1'b0;
         if (c >= 3) begin
            check("R8 strobe timing", 48'(out_valid), 48'((c == n + 3) || (c == 2*n + 3)));
            if (c == n + 3 || c == 2*n + 3) begin
               sa = 0; sb = 0;
               for (int k = 0; k < n; k++) begin
                  sa += pat(k + ((c == n + 3) ? 0 : n), 7 + code);
                  sb += pat(k + ((c == n + 3) ? 0 : n), 11 + code);
               end
               check("R7 average lane A", out_a, pack(sa >>> sh, 0));
               check("R7 average lane B", out_b, pack(sb >>> sh, 0));
            end
         end
         samp_a = 16'(pat(c, 7 + code));
         samp_b = 16'(pat(c, 11 + code));
      end
      dec_en = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; ddc_en = 1'b0; dec_en = 1'b0; sync = 1'b0;
      dec_sel = 2'd0; tune_word = 24'h0; phase_init = 24'h0;
      samp_a = 16'sd1234; samp_b = -16'sd4321;
      t_reset();
      t_bypass();
      t_quarter(24'h400000);
      t_quarter(24'h40000F);
      t_init(24'h80000F, 2);
      t_init(24'h40000A, 1);
      t_tune_mask();
      t_mix_latency();
      for (int code = 0; code < 4; code++) t_decim(code);
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule